// File: doc/BRIEF.md
# Multi-Mode External Interrupt Sense and Priority Selector

This block watches eight external interrupt pins. For each pin it picks one of four ways of sensing a request, and it gives each pin its own 4-bit priority. Pin inputs pass through a two-stage synchronizer. Level-sensed pins request for as long as they are held low and never latch. Edge-sensed pins record the selected transition and keep that record until the CPU accepts it. On every cycle an arbiter picks the strongest active request. It presents the winner's pin number and priority level on registered outputs.

Software sets the sense fields and the priority fields through a small word-wide register port. The same port returns the current request bit of every pin. When the CPU takes an interrupt, it pulses an accept strobe together with the pin number it took. That strobe clears the recorded edge of that one pin only.

Top module: `irq_sense_prio`

## Requirements
- R1: After reset the outputs req_valid, req_idx and req_level are 0, every sense field and priority field reads 0, and the status word reads 0 while all pins are high.
- R2: Address 0 holds the sense fields. Pin n uses bits [2n+1:2n], with the codes 00 = low level, 01 = falling edge, 10 = rising edge and 11 = both edges. The word reads back as written.
- R3: Address 1 holds the priorities of pins 0 to 3 and address 2 holds those of pins 4 to 7, each pin in bits [4k+3:4k] of its word (k = n mod 4). Both words read back as written.
- R4: In low-level mode a pin requests only while its synchronized input is low. The request drops when the input returns high, and an accept strobe has no effect on it.
- R5: In an edge mode only the selected transition raises the request. The request then stays set through later pin activity until it is accepted or the mode is changed.
- R6: Address 3 returns the current request bit of each pin in bits [7:0], with bit n for pin n and zeros above.
- R7: A pin whose priority is 0 never wins, even while it is requesting.
- R8: The request with the highest priority level wins. When levels are equal, the higher pin number wins.
- R9: An accept strobe clears the recorded edge of the named pin only. If a new edge of that pin is detected in the same cycle, the request stays set.
- R10: Writing a different sense code for a pin clears that pin's recorded edge.
- R11: The outputs are registered. A level request shows on the third rising clock edge after the pin falls (two synchronizer stages plus the output register). An edge request shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ack | input | 1 | Accept strobe from the CPU |
| ack_idx | input | 3 | Pin number being accepted |
| req_valid | output | 1 | A winning request exists |
| req_idx | output | 3 | Winning pin number |
| req_level | output | 4 | Priority level of the winner |

## Verification
Each sense mode gets a pin waveform that separates it from the others. A held-low pin must request in level mode and stop as soon as the pin is released. In falling-edge mode a single fall must stay latched after the pin goes high again. In rising-edge mode a fall must be ignored and only the rise counts. In both-edges mode either transition counts, and one test lands a fresh edge in the same cycle as its accept. Arbitration is tried with a requesting pin at priority 0, with two equal-level pins, and with a lower-numbered pin at a higher level, which together separate disabling, the tie rule and the level comparison. Changing a pin's mode while its edge is latched, and accepting the wrong index, show that pending edges are cleared only by the intended events.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int PRIO_W = 4;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  // Does the transition prev->cur count as an event under mode m?
  function automatic logic edge_event(sense_e m, logic prev, logic cur);
    case (m)
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      SENSE_BOTH: return prev ^ cur;
      default:    return 1'b0;
    endcase
  endfunction

  // Candidate takes over when enabled and not weaker (ascending scan => higher index wins ties)
  function automatic logic takes_over(logic [PRIO_W-1:0] cand, logic [PRIO_W-1:0] best);
    return (cand != '0) && (cand >= best);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_a,
  output logic [NPINS-1:0] pin_s
);
  logic [NPINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= pin_a;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_s = stage_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect import irq_sense_pkg::*; #(
  parameter int NPINS = 8,
  localparam int IW = $clog2(NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_s,
  input  logic [2*NPINS-1:0] sense_flat,
  input  logic [NPINS-1:0]   mode_chg,
  input  logic               ack,
  input  logic [IW-1:0]      ack_idx,
  output logic [NPINS-1:0]   hit,
  output logic [NPINS-1:0]   pend,
  output logic [NPINS-1:0]   lvl_mask,
  output logic [NPINS-1:0]   req_vec
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    sense_e mode;
    logic   acc_me;
    assign mode        = sense_e'(sense_flat[2*i +: 2]);
    assign lvl_mask[i] = (mode == SENSE_LOW);
    assign hit[i]      = edge_event(mode, prev_q[i], pin_s[i]);
    assign acc_me      = ack && (ack_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        pend[i] <= 1'b0;
      else if (mode_chg[i] || lvl_mask[i]) pend[i] <= 1'b0;
      else if (hit[i])                   pend[i] <= 1'b1;
      else if (acc_me)                   pend[i] <= 1'b0;
    end

    assign req_vec[i] = lvl_mask[i] ? ~pin_s[i] : pend[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_sense_pkg::*; #(
  parameter int NPINS = 8,
  localparam int IW = $clog2(NPINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        req_vec,
  input  logic [NPINS*PRIO_W-1:0] prio_flat,
  output logic                    req_valid,
  output logic [IW-1:0]           req_idx,
  output logic [PRIO_W-1:0]       req_level
);
  logic              any_c;
  logic [IW-1:0]     idx_c;
  logic [PRIO_W-1:0] lvl_c;

  always_comb begin
    any_c = 1'b0;
    idx_c = '0;
    lvl_c = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (req_vec[i] && takes_over(prio_flat[i*PRIO_W +: PRIO_W], lvl_c)) begin
        any_c = 1'b1;
        idx_c = IW'(i);
        lvl_c = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_idx   <= '0;
      req_level <= '0;
    end else begin
      req_valid <= any_c;
      req_idx   <= idx_c;
      req_level <= lvl_c;
    end
  end
endmodule

// File: rtl/irq_sense_prio.sv
module irq_sense_prio import irq_sense_pkg::*; #(
  parameter int NPINS = 8,
  localparam int IW        = $clog2(NPINS),
  localparam int DW        = 2*NPINS,
  localparam int NPRW      = NPINS*PRIO_W/DW,
  localparam int STAT_ADDR = NPRW + 1,
  localparam int AW        = $clog2(STAT_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  irq_pin,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              ack,
  input  logic [IW-1:0]     ack_idx,
  output logic              req_valid,
  output logic [IW-1:0]     req_idx,
  output logic [PRIO_W-1:0] req_level
);
  logic [DW-1:0]           sense_q;
  logic [NPINS*PRIO_W-1:0] prio_q;
  logic [NPINS-1:0]        pin_s, mode_chg, hit, pend, lvl_mask, req_vec;
  logic                    wr_sense;

  assign wr_sense = wr_en && (wr_addr == AW'(0));

  for (genvar i = 0; i < NPINS; i++) begin : g_chg
    assign mode_chg[i] = wr_sense && (wr_data[2*i +: 2] != sense_q[2*i +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sense_q <= '0;
    else if (wr_sense) sense_q <= wr_data;
  end

  for (genvar w = 0; w < NPRW; w++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 prio_q[w*DW +: DW] <= '0;
      else if (wr_en && (wr_addr == AW'(w + 1))) prio_q[w*DW +: DW] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(0)) rd_data = sense_q;
    else if (rd_addr == AW'(STAT_ADDR)) rd_data[NPINS-1:0] = req_vec;
    else begin
      for (int w = 0; w < NPRW; w++)
        if (rd_addr == AW'(w + 1)) rd_data = prio_q[w*DW +: DW];
    end
  end

  irq_pin_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_a(irq_pin), .pin_s(pin_s)
  );

  irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sense_flat(sense_q),
    .mode_chg(mode_chg), .ack(ack), .ack_idx(ack_idx),
    .hit(hit), .pend(pend), .lvl_mask(lvl_mask), .req_vec(req_vec)
  );

  irq_arbiter #(.NPINS(NPINS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .prio_flat(prio_q),
    .req_valid(req_valid), .req_idx(req_idx), .req_level(req_level)
  );
endmodule

// File: rtl/irq_sense_prio_chk.sv
module irq_sense_prio_chk import irq_sense_pkg::*; #(
  parameter int NPINS = 8,
  localparam int IW = $clog2(NPINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [IW-1:0]     ack_idx,
  input logic              req_valid,
  input logic [IW-1:0]     req_idx,
  input logic [PRIO_W-1:0] req_level,
  input logic [NPINS-1:0]  pin_s,
  input logic [NPINS-1:0]  req_vec,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  mode_chg,
  input logic [NPINS-1:0]  lvl_mask
);
  p_no_zero_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_level != '0));

  p_winner_was_requesting_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((($past(req_vec) >> req_idx) & NPINS'(1)) != '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    p_level_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mask[i] && pin_s[i]) |-> !req_vec[i]);

    p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !(ack && ack_idx == IW'(i)) && !mode_chg[i]) |=> pend[i]);

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_idx == IW'(i) && !hit[i] && !mode_chg[i]) |=> !pend[i]);

    p_accept_keeps_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_idx == IW'(i) && hit[i] && !mode_chg[i]) |=> pend[i]);

    p_mode_change_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg[i] |=> !pend[i]);
  end
endmodule

bind irq_sense_prio irq_sense_prio_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_idx(ack_idx),
  .req_valid(req_valid), .req_idx(req_idx), .req_level(req_level),
  .pin_s(pin_s), .req_vec(req_vec), .pend(pend), .hit(hit),
  .mode_chg(mode_chg), .lvl_mask(lvl_mask)
);

// File: tb/tb_irq_sense_prio.sv
`timescale 1ns/1ps
module tb_irq_sense_prio;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq_pin;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        ack;
  logic [2:0]  ack_idx;
  logic        req_valid;
  logic [2:0]  req_idx;
  logic [3:0]  req_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_sense_prio dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack(ack), .ack_idx(ack_idx), .req_valid(req_valid), .req_idx(req_idx),
    .req_level(req_level)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_pin = 8'hFF; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ack = 1'b0; ack_idx = '0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_chk(string req, logic [1:0] a, logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic accept(logic [2:0] idx);
    @(negedge clk);
    ack = 1'b1; ack_idx = idx;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic out_chk(string req, logic v, logic [2:0] i, logic [3:0] l);
    chk({req, " valid"}, req_valid, v);
    if (v) begin
      chk({req, " idx"}, req_idx, i);
      chk({req, " level"}, req_level, l);
    end
  endtask

  task automatic t_reset();
    do_reset();
    out_chk("R1 reset", 1'b0, 3'd0, 4'd0);
    chk("R1 reset idx", req_idx, 0);
    chk("R1 reset level", req_level, 0);
    reg_chk("R1 sense reset", 2'd0, 16'h0000);
    reg_chk("R1 prio lo reset", 2'd1, 16'h0000);
    reg_chk("R1 prio hi reset", 2'd2, 16'h0000);
    reg_chk("R1 status reset", 2'd3, 16'h0000);
  endtask

  task automatic t_regs();
    do_reset();
    reg_wr(2'd0, 16'hA5C3);
    reg_chk("R2 sense readback", 2'd0, 16'hA5C3);
    reg_wr(2'd1, 16'h1234);
    reg_wr(2'd2, 16'hFEDC);
    reg_chk("R3 prio lo readback", 2'd1, 16'h1234);
    reg_chk("R3 prio hi readback", 2'd2, 16'hFEDC);
  endtask

  // pin 2, level mode (code 00), priority 5 at address 1 bits [11:8]
  task automatic t_level();
    do_reset();
    reg_wr(2'd1, 16'h0500);
    @(negedge clk); irq_pin[2] = 1'b0;
    wait_neg(2);
    chk("R11 level not yet", req_valid, 0);
    wait_neg(1);
    out_chk("R11 level on third edge", 1'b1, 3'd2, 4'd5);
    reg_chk("R6 status level", 2'd3, 16'h0004);
    accept(3'd2);
    wait_neg(2);
    out_chk("R4 accept ignored in level", 1'b1, 3'd2, 4'd5);
    irq_pin[2] = 1'b1;
    wait_neg(3);
    chk("R4 drops on release", req_valid, 0);
    reg_chk("R4 status cleared", 2'd3, 16'h0000);
  endtask

  // pin 1 falling (01 at bits [3:2]), priority 7 at address 1 bits [7:4]
  task automatic t_fall();
    do_reset();
    reg_wr(2'd0, 16'h0004);
    reg_wr(2'd1, 16'h0070);
    @(negedge clk); irq_pin[1] = 1'b0;
    wait_neg(3);
    chk("R11 edge one extra edge", req_valid, 0);
    wait_neg(1);
    out_chk("R11 edge latency", 1'b1, 3'd1, 4'd7);
    irq_pin[1] = 1'b1;
    wait_neg(6);
    out_chk("R5 falling latched", 1'b1, 3'd1, 4'd7);
    reg_chk("R6 status latched", 2'd3, 16'h0002);
    accept(3'd0);
    wait_neg(2);
    out_chk("R9 other index kept", 1'b1, 3'd1, 4'd7);
    accept(3'd1);
    wait_neg(1);
    chk("R9 accept clears", req_valid, 0);
    reg_chk("R9 status after accept", 2'd3, 16'h0000);
  endtask

  // pin 6 rising (10 at bits [13:12]), priority 9 at address 2 bits [11:8]
  task automatic t_rise();
    do_reset();
    reg_wr(2'd0, 16'h2000);
    reg_wr(2'd2, 16'h0900);
    @(negedge clk); irq_pin[6] = 1'b0;
    wait_neg(6);
    chk("R5 fall ignored in rising mode", req_valid, 0);
    irq_pin[6] = 1'b1;
    wait_neg(6);
    out_chk("R5 rise latched", 1'b1, 3'd6, 4'd9);
  endtask

  // pin 3 both (11 at bits [7:6]), priority 4 at address 1 bits [15:12]
  task automatic t_both();
    do_reset();
    reg_wr(2'd0, 16'h00C0);
    reg_wr(2'd1, 16'h4000);
    @(negedge clk); irq_pin[3] = 1'b0;
    wait_neg(6);
    out_chk("R5 both: fall", 1'b1, 3'd3, 4'd4);
    accept(3'd3);
    wait_neg(1);
    chk("R9 both cleared", req_valid, 0);
    irq_pin[3] = 1'b1;
    wait_neg(6);
    out_chk("R5 both: rise", 1'b1, 3'd3, 4'd4);
    // new fall detected in the same cycle as the accept
    irq_pin[3] = 1'b0;
    wait_neg(2);
    ack = 1'b1; ack_idx = 3'd3;
    @(negedge clk);
    ack = 1'b0;
    wait_neg(3);
    out_chk("R9 collision kept pending", 1'b1, 3'd3, 4'd4);
    accept(3'd3);
    wait_neg(1);
    chk("R9 second accept clears", req_valid, 0);
  endtask

  // level mode everywhere; address1 = pin0:3, pin2:3 (pin1 at 0); address2 pin5:3
  task automatic t_prio();
    do_reset();
    reg_wr(2'd1, 16'h0303);
    reg_wr(2'd2, 16'h0030);
    @(negedge clk); irq_pin = ~8'h02;
    wait_neg(4);
    chk("R7 priority 0 never wins", req_valid, 0);
    reg_chk("R6 status disabled pin", 2'd3, 16'h0002);
    irq_pin = ~8'h07;
    wait_neg(4);
    out_chk("R8 tie higher index", 1'b1, 3'd2, 4'd3);
    irq_pin = ~8'h27;
    wait_neg(4);
    out_chk("R8 tie pin5", 1'b1, 3'd5, 4'd3);
    reg_wr(2'd2, 16'h003E);
    irq_pin = ~8'h37;
    wait_neg(4);
    out_chk("R8 higher level beats index", 1'b1, 3'd4, 4'd14);
  endtask

  // pin 5 falling (01 at bits [11:10]), priority 6 at address 2 bits [7:4]
  task automatic t_chg();
    do_reset();
    reg_wr(2'd0, 16'h0400);
    reg_wr(2'd2, 16'h0060);
    @(negedge clk); irq_pin[5] = 1'b0;
    wait_neg(6);
    out_chk("R10 pending before change", 1'b1, 3'd5, 4'd6);
    reg_wr(2'd0, 16'h0800);
    wait_neg(2);
    chk("R10 change clears", req_valid, 0);
    reg_chk("R10 status cleared", 2'd3, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_level();
    t_fall();
    t_rise();
    t_both();
    t_prio();
    t_chg();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule